// File: doc/BRIEF.md
# Two-Agent Weighted Burst Arbiter

This block shares one memory port between two requesting agents. Each agent has a request, a grant and a word-accept signal. A word counts when the agent holds its grant and raises its accept in the same cycle. The arbiter runs one of two policies, chosen by a mode input:

- **Round robin:** a grant lasts a programmable number of accepted words, and the agents take turns.
- **Fixed priority:** each agent carries a two-bit level, and the better level wins.

When a grant finishes, the port stays unassigned for an idle gap taken from the agent that just finished, and only then is the next agent chosen.

An enable input selects the source of the grant outputs. While the enable is low, the grants of an external default arbiter are forwarded unchanged and the internal sequencer waits in its idle state. The configuration inputs are expected to come from a register bank that resets to these values:

- enable off
- round robin
- quota of four words for each agent
- level 1 for agent 0 and level 0 for agent 1

The memory datapath and the address decoding sit outside this block.

Top module: `wba_arb`

## Requirements
- R1: While `cfg_en_i` is 0, `gnt_o` equals `dflt_gnt_i` in the same cycle, whatever the requests are.
- R2: While `cfg_en_i` is 1, at most one bit of `gnt_o` is high, and a grant bit is high only while that agent's request is high.
- R3: In round robin (`cfg_rr_i` = 1) with both agents requesting, the grant alternates between the agents. Each grant lasts until the agent has had as many accepted words (cycles with grant and `ack_i` both high) as its quota, a value from 1 to 8191.
- R4: A quota input of 0 is treated as a quota of 1 word.
- R5: After a grant ends by using up its quota, no grant is issued for exactly as many cycles as the finishing agent's delay input (0 to 31). With a delay of 0, the next grant is visible in the very next cycle.
- R6: In fixed priority (`cfg_rr_i` = 0), level 0 is the highest, 1 is medium and 2 is the lowest, so the requesting agent with the numerically lower level is granted. On equal levels, agent 0 is granted.
- R7: In fixed priority, an agent whose level is 3 is never granted.
- R8: If the owning agent drops its request before using its quota, its grant falls in that same cycle. The idle interval that follows is then the finishing agent's delay plus one cycle.
- R9: In round robin, an agent that is the only requester is granted again once its own delay has expired.
- R10: No grant is issued while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en_i | input | 1 | 1: internal arbiter drives grants; 0: forward the default grants |
| cfg_rr_i | input | 1 | Policy: 1 round robin, 0 fixed priority |
| cfg_quota0_i | input | 13 | Agent 0 words per grant (0 acts as 1) |
| cfg_quota1_i | input | 13 | Agent 1 words per grant (0 acts as 1) |
| cfg_gap0_i | input | 5 | Idle cycles after an agent 0 grant |
| cfg_gap1_i | input | 5 | Idle cycles after an agent 1 grant |
| cfg_prio0_i | input | 2 | Agent 0 level (0 best, 3 excluded) |
| cfg_prio1_i | input | 2 | Agent 1 level (0 best, 3 excluded) |
| req_i | input | 2 | Request, bit n for agent n |
| ack_i | input | 2 | Word accept, bit n for agent n |
| dflt_gnt_i | input | 2 | Grants from the external default arbiter |
| gnt_o | output | 2 | Grant, bit n for agent n |

## Verification
The hardest case to reach is a grant that ends early while the other agent waits. The request has to drop at a known word count, and the interval up to the next grant must then be exactly the delay plus one. The stimulus gets there in two steps:

- It raises agent 0's request one cycle before agent 1's, so agent 0 is known to win the first round-robin decision.
- It counts clock edges after that grant and drops the request after the second accepted word.

A scoreboard compares each observed burst's agent, word count and preceding idle interval. Another hard case is a quota of one word combined with a zero delay. There a new decision is taken at every edge, and the stimulus checks that the handover happens back to back.

// File: rtl/wba_pkg.sv
// Shared types for the two-agent weighted burst arbiter.
// Assumes: exactly two agents; states are only used inside the arbiter.
package wba_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_GAP   = 2'd2
    } arb_state_e;
endpackage

// File: rtl/wba_pick.sv
// Winner selection for two agents under round robin or fixed priority.
// Assumes: last_i names the agent granted most recently; a level of all ones
// excludes an agent under fixed priority; equal levels favour agent 0.
module wba_pick #(
    parameter int PW = 2
) (
    input  logic [1:0]    req_i,
    input  logic          rr_mode_i,
    input  logic          last_i,
    input  logic [PW-1:0] prio0_i,
    input  logic [PW-1:0] prio1_i,
    output logic          valid_o,
    output logic          win_o
);
    localparam logic [PW-1:0] LVL_OFF = '1;

    logic [1:0] elig;

    // Purpose: mask excluded agents, then choose the winner by policy.
    always_comb begin
        if (rr_mode_i) begin
            elig = req_i;
        end else begin
            elig = req_i & {prio1_i != LVL_OFF, prio0_i != LVL_OFF};
        end
        valid_o = |elig;
        if (elig == 2'b11) begin
            win_o = rr_mode_i ? ~last_i : (prio1_i < prio0_i);
        end else begin
            win_o = elig[1];
        end
    end
endmodule

// File: rtl/wba_wordcnt.sv
// Counts accepted words within one grant and flags the last one.
// Assumes: a quota of zero behaves as one word; clr_i has priority over inc_i.
module wba_wordcnt #(
    parameter int QW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    input  logic [QW-1:0] quota_i,
    output logic          last_o
);
    localparam logic [QW-1:0] ONE = {{(QW-1){1'b0}}, 1'b1};

    logic [QW-1:0] cnt_q;
    logic [QW-1:0] lim;

    // Purpose: index of the final word of the grant.
    always_comb begin
        lim = (quota_i == '0) ? '0 : quota_i - ONE;
    end

    assign last_o = (cnt_q == lim);

    // Purpose: word count register, cleared at each grant boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/wba_gapcnt.sv
// Down counter that times the idle interval between grants.
// Assumes: loaded with a non-zero value only; done_o is high in the last idle cycle.
module wba_gapcnt #(
    parameter int GW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [GW-1:0] val_i,
    input  logic          run_i,
    output logic          done_o
);
    localparam logic [GW-1:0] ONE = {{(GW-1){1'b0}}, 1'b1};

    logic [GW-1:0] cnt_q;

    assign done_o = (cnt_q <= ONE);

    // Purpose: load on grant end, count down while idling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (run_i && !done_o) begin
            cnt_q <= cnt_q - ONE;
        end
    end
endmodule

// File: rtl/wba_arb.sv
// Two-agent weighted burst arbiter for one shared memory port.
// Grants last a word quota (round robin) or follow priority levels (fixed),
// with a per-agent idle gap after each grant. With the enable low the
// external default grants are forwarded.
// Assumes: configuration changes only while no grant or gap is in progress.
module wba_arb #(
    parameter int QW = 13,
    parameter int GW = 5,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en_i,
    input  logic          cfg_rr_i,
    input  logic [QW-1:0] cfg_quota0_i,
    input  logic [QW-1:0] cfg_quota1_i,
    input  logic [GW-1:0] cfg_gap0_i,
    input  logic [GW-1:0] cfg_gap1_i,
    input  logic [PW-1:0] cfg_prio0_i,
    input  logic [PW-1:0] cfg_prio1_i,
    input  logic [1:0]    req_i,
    input  logic [1:0]    ack_i,
    input  logic [1:0]    dflt_gnt_i,
    output logic [1:0]    gnt_o
);
    import wba_pkg::*;

    arb_state_e    state_q;
    logic          owner_q;
    logic [1:0]    own_gnt;
    logic          word_acc;
    logic          last_word;
    logic          grant_end;
    logic          gap_done;
    logic          pick_valid;
    logic          pick_win;
    logic [GW-1:0] gap_sel;
    logic [QW-1:0] quota_sel;

    wba_pick #(.PW(PW)) pick_i (
        .req_i     (req_i),
        .rr_mode_i (cfg_rr_i),
        .last_i    (owner_q),
        .prio0_i   (cfg_prio0_i),
        .prio1_i   (cfg_prio1_i),
        .valid_o   (pick_valid),
        .win_o     (pick_win)
    );

    wba_wordcnt #(.QW(QW)) wcnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (grant_end || (state_q != ST_GRANT)),
        .inc_i   (word_acc),
        .quota_i (quota_sel),
        .last_o  (last_word)
    );

    wba_gapcnt #(.GW(GW)) gcnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (grant_end),
        .val_i  (gap_sel),
        .run_i  (state_q == ST_GAP),
        .done_o (gap_done)
    );

    // Purpose: per-owner configuration selection.
    always_comb begin
        gap_sel   = owner_q ? cfg_gap1_i : cfg_gap0_i;
        quota_sel = owner_q ? cfg_quota1_i : cfg_quota0_i;
    end

    // Purpose: internal grant, withdrawn as soon as the owner stops requesting.
    always_comb begin
        own_gnt = '0;
        if (state_q == ST_GRANT && req_i[owner_q]) begin
            own_gnt[owner_q] = 1'b1;
        end
    end

    // Purpose: word accept and end-of-grant detection.
    always_comb begin
        word_acc  = |(own_gnt & ack_i);
        grant_end = (state_q == ST_GRANT) && (!req_i[owner_q] || (word_acc && last_word));
    end

    // Purpose: output source selection by the enable.
    assign gnt_o = cfg_en_i ? own_gnt : dflt_gnt_i;

    // Purpose: grant sequencer; owner_q doubles as the round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= 1'b1;
        end else if (!cfg_en_i) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (pick_valid) begin
                        state_q <= ST_GRANT;
                        owner_q <= pick_win;
                    end
                end
                ST_GRANT: begin
                    if (grant_end) begin
                        if (gap_sel != '0) begin
                            state_q <= ST_GAP;
                        end else if (pick_valid) begin
                            state_q <= ST_GRANT;
                            owner_q <= pick_win;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_done) begin
                        if (pick_valid) begin
                            state_q <= ST_GRANT;
                            owner_q <= pick_win;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wba_arb_chk.sv
// Property checker for wba_arb, attached by bind below.
// Assumes: configuration is stable across a grant and its following gap.
module wba_arb_chk #(
    parameter int GW = 5,
    parameter int PW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_en_i,
    input logic          cfg_rr_i,
    input logic [GW-1:0] cfg_gap0_i,
    input logic [GW-1:0] cfg_gap1_i,
    input logic [PW-1:0] cfg_prio0_i,
    input logic [PW-1:0] cfg_prio1_i,
    input logic [1:0]    req_i,
    input logic [1:0]    dflt_gnt_i,
    input logic [1:0]    gnt_o
);
    localparam int IW = GW + 1;
    localparam logic [IW-1:0] IONE = {{(IW-1){1'b0}}, 1'b1};

    logic [IW-1:0] idle_q;
    logic          seen_q;
    logic          prev_q;
    logic [IW-1:0] need;

    assign need = prev_q ? {1'b0, cfg_gap1_i} : {1'b0, cfg_gap0_i};

    // Purpose: track idle cycles since the last observed grant.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_en_i) begin
            idle_q <= '0;
            seen_q <= 1'b0;
            prev_q <= 1'b0;
        end else if (gnt_o != 2'b00) begin
            idle_q <= '0;
            seen_q <= 1'b1;
            prev_q <= gnt_o[1];
        end else if (idle_q != '1) begin
            idle_q <= idle_q + IONE;
        end
    end

    a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en_i |-> gnt_o == dflt_gnt_i);

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en_i |-> $onehot0(gnt_o));

    a_r2_req0: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en_i && gnt_o[0] |-> req_i[0]);

    a_r2_req1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en_i && gnt_o[1] |-> req_i[1]);

    a_r5_gap_kept: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en_i && seen_q && (gnt_o != 2'b00) && (idle_q != '0) |-> idle_q >= need);

    a_r7_lvl_off0: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en_i && !cfg_rr_i && (cfg_prio0_i == {PW{1'b1}}) |-> !gnt_o[0]);

    a_r7_lvl_off1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en_i && !cfg_rr_i && (cfg_prio1_i == {PW{1'b1}}) |-> !gnt_o[1]);

    a_r10_post_reset: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en_i && $past(!rst_n) |-> gnt_o == 2'b00);
endmodule

bind wba_arb wba_arb_chk #(.GW(GW), .PW(PW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en_i    (cfg_en_i),
    .cfg_rr_i    (cfg_rr_i),
    .cfg_gap0_i  (cfg_gap0_i),
    .cfg_gap1_i  (cfg_gap1_i),
    .cfg_prio0_i (cfg_prio0_i),
    .cfg_prio1_i (cfg_prio1_i),
    .req_i       (req_i),
    .dflt_gnt_i  (dflt_gnt_i),
    .gnt_o       (gnt_o)
);

// File: tb/wba_arb_tb_top.sv
`timescale 1ns/1ps
module wba_arb_tb_top;
    typedef struct {
        int    agent;
        int    words;
        int    gap;
        string tag;
    } burst_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        rr = 1'b1;
    logic [12:0] q0 = 13'd4;
    logic [12:0] q1 = 13'd4;
    logic [4:0]  g0 = 5'd0;
    logic [4:0]  g1 = 5'd0;
    logic [1:0]  p0 = 2'd1;
    logic [1:0]  p1 = 2'd0;
    logic [1:0]  req = 2'b00;
    logic        ack0 = 1'b1;
    logic        ack1 = 1'b1;
    logic [1:0]  ack;
    logic [1:0]  dflt = 2'b00;
    logic [1:0]  gnt;

    int     checks = 0;
    int     fails = 0;
    bit     mon_on = 1'b0;
    bit     ack_tog = 1'b0;
    burst_t exp_q[$];

    assign ack = {ack1, ack0};

    always #2 clk = ~clk;

    wba_arb dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_en_i     (en),
        .cfg_rr_i     (rr),
        .cfg_quota0_i (q0),
        .cfg_quota1_i (q1),
        .cfg_gap0_i   (g0),
        .cfg_gap1_i   (g1),
        .cfg_prio0_i  (p0),
        .cfg_prio1_i  (p1),
        .req_i        (req),
        .ack_i        (ack),
        .dflt_gnt_i   (dflt),
        .gnt_o        (gnt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input int agent, input int words, input int gap, input string tag);
        burst_t b;
        b.agent = agent;
        b.words = words;
        b.gap   = gap;
        b.tag   = tag;
        exp_q.push_back(b);
    endtask

    // Raise agent 0 one cycle ahead so it wins the first round-robin decision.
    task automatic start_rr();
        @(posedge clk); #1 req[0] = 1'b1;
        @(posedge clk); #1 req[1] = 1'b1;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(posedge clk); #1 req = 2'b00;
        repeat (40) @(posedge clk);
    endtask

    // Accept pattern for agent 0: steady or toggling every cycle.
    initial begin
        forever begin
            @(posedge clk);
            #1 ack0 = ack_tog ? ~ack0 : 1'b1;
        end
    end

    // Monitor: builds observed bursts and compares them against the queue.
    initial begin
        int cur;
        int words;
        int idle;
        int gap_obs;
        burst_t e;
        cur = -1; words = 0; idle = 0; gap_obs = 0;
        forever begin
            @(negedge clk);
            if (!mon_on) begin
                cur = -1;
                idle = 0;
            end else begin
                if (cur >= 0 && !gnt[cur]) begin
                    if (exp_q.size() > 0) begin
                        e = exp_q.pop_front();
                        checks++;
                        if (e.agent != cur || e.words != words || (e.gap >= 0 && e.gap != gap_obs)) begin
                            fails++;
                            $display("FAIL %s: agent/words/gap actual %0d/%0d/%0d expected %0d/%0d/%0d",
                                     e.tag, cur, words, gap_obs, e.agent, e.words, e.gap);
                        end
                    end
                    cur = -1;
                    idle = 0;
                end
                if (cur < 0 && gnt != 2'b00) begin
                    cur = gnt[1] ? 1 : 0;
                    words = 0;
                    gap_obs = idle;
                end
                if (cur >= 0) begin
                    if (ack[cur]) words++;
                end else begin
                    idle++;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int any0;
        int any1;
        // R10: no grant while reset is held, even with both requests up
        req = 2'b11;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(gnt == 2'b00, "R10 grant in reset", gnt, 0);
        @(posedge clk); #1 req = 2'b00;
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        mon_on = 1'b1;

        // R3: round robin alternation, quota words, toggling accepts; R5 gaps
        q0 = 13'd3; q1 = 13'd2; g0 = 5'd2; g1 = 5'd1; ack_tog = 1'b1;
        push(0, 3, -1, "R3 rr first");
        push(1, 2, 2, "R5 rr gap after agent 0");
        push(0, 3, 1, "R3 rr gap after agent 1");
        push(1, 2, 2, "R3 rr alternate");
        start_rr();
        drain();
        ack_tog = 1'b0;

        // R4: quota 0 acts as 1; R5: zero delay hands over next cycle
        q0 = 13'd0; q1 = 13'd1; g0 = 5'd0; g1 = 5'd0;
        push(0, 1, -1, "R4 quota zero");
        push(1, 1, 0, "R5 zero delay handover");
        push(0, 1, 0, "R4 quota zero again");
        push(1, 1, 0, "R5 zero delay handover again");
        start_rr();
        drain();

        // R9: single requester re-granted after its own delay
        q1 = 13'd3; g1 = 5'd4;
        push(1, 3, -1, "R9 single first");
        push(1, 3, 4, "R9 single regrant");
        push(1, 3, 4, "R9 single regrant again");
        @(posedge clk); #1 req[1] = 1'b1;
        drain();

        // R8: early request drop ends grant, idle is delay plus one
        q0 = 13'd8; q1 = 13'd2; g0 = 5'd3; g1 = 5'd1;
        push(0, 2, -1, "R8 early end words");
        push(1, 2, 4, "R8 idle after early end");
        push(1, 2, 1, "R9 regrant after drop");
        start_rr();
        @(posedge clk);
        @(posedge clk); #1 req[0] = 1'b0;
        drain();

        // R6: fixed priority, lower level wins
        rr = 1'b0; p0 = 2'd1; p1 = 2'd0; q0 = 13'd2; q1 = 13'd2; g0 = 5'd1; g1 = 5'd1;
        push(1, 2, -1, "R6 level 0 beats level 1");
        push(1, 2, 1, "R6 level 0 keeps winning");
        push(1, 2, 1, "R6 level 0 keeps winning again");
        @(posedge clk); #1 req = 2'b11;
        drain();

        // R6: equal levels favour agent 0
        p0 = 2'd2; p1 = 2'd2;
        push(0, 2, -1, "R6 tie agent 0");
        push(0, 2, 1, "R6 tie agent 0 again");
        push(0, 2, 1, "R6 tie agent 0 third");
        @(posedge clk); #1 req = 2'b11;
        drain();

        // R7: level 3 never granted; R2: no grant to a silent agent
        p0 = 2'd0; p1 = 2'd3;
        @(posedge clk); #1 req = 2'b10;
        any0 = 0; any1 = 0;
        repeat (20) begin
            @(negedge clk);
            if (gnt[0]) any0++;
            if (gnt[1]) any1++;
        end
        check(any1 == 0, "R7 level 3 agent granted", any1, 0);
        check(any0 == 0, "R2 grant to non-requesting agent", any0, 0);
        @(posedge clk); #1 req = 2'b00;
        repeat (40) @(posedge clk);
        p0 = 2'd3; p1 = 2'd2; q1 = 13'd2; g1 = 5'd1;
        push(1, 2, -1, "R7 level 3 rival skipped");
        push(1, 2, 1, "R7 level 3 rival skipped again");
        @(posedge clk); #1 req = 2'b11;
        drain();

        // R1: passthrough of the default grants while disabled
        mon_on = 1'b0;
        en = 1'b0;
        @(posedge clk); #1 dflt = 2'b10; req = 2'b01;
        @(negedge clk);
        check(gnt == 2'b10, "R1 passthrough 10", gnt, 2);
        @(posedge clk); #1 dflt = 2'b01; req = 2'b10;
        @(negedge clk);
        check(gnt == 2'b01, "R1 passthrough 01", gnt, 1);
        @(posedge clk); #1 dflt = 2'b00; req = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(gnt == 2'b00, "R1 passthrough 00", gnt, 0);

        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule